// File: doc/BRIEF.md
# Multi-Channel Input Capture Timer

This block is a bus-programmed timer with one free-running up-counter and four capture channels. The counter steps once every (divider + 1) count events and wraps to zero after reaching a programmable top value. Each wrap raises an update flag. The count source is either the core clock or the rising edges of a slow external clock pin, which pass through a synchroniser first.

Each channel watches one input pin. The pin is synchronised and then filtered by a programmable run-length qualifier. The channel detects rising, falling or both edges, and it can count 1, 2, 4 or 8 qualifying edges before each capture. On a capture, the counter value is copied into the channel's own register and the channel's capture flag is set. If a capture arrives while that flag is still set, an overcapture flag is raised as well. Software clears flags by writing zeros to the status word, or by reading the capture register. A single interrupt line combines the update flag and the capture flags with their enables.

Top module: `icap_timer`

## Requirements
- R1: After reset every register reads 0, except the top value, which reads all ones. The counter reads 0 and `irq` is low.
- R2: While CTRL bit 0 (run) is 1 and the internal source is selected, the counter advances once every DIV+1 clock cycles, where DIV is held in register PRESC. While run is 0, the counter holds its value.
- R3: When a count step occurs with the counter equal to TOP, the counter becomes 0 and STAT bit 0 (update) is set.
- R4: Writing 1 to bit 0 of EVGEN sets the counter and the divider phase to 0.
- R5: Writing a ratio r to RATIO stores min(r-1, 0xFFFF) in PRESC. Writing r = 0 clears run and leaves PRESC unchanged.
- R6: With CTRL bit 1 set, the count source is the synchronised rising edges of `ext_clk_in` instead of the clock.
- R7: CAPEN holds one nibble per channel i, starting at bit 4i: bit 4i enables, bit 4i+1 is P, bit 4i+3 is NP. P=0 captures on rising edges, P=1 with NP=0 captures on falling edges, and P=1 with NP=1 captures on both edges. With the enable bit clear, no capture happens.
- R8: A capture loads the current counter value into CAPTi and sets STAT bit 1+i. Capture happens only when the channel's select field (mode bits [1:0]) equals 01. Channels 0 and 1 take their mode bytes from MODE_LO bits [7:0] and [15:8]. Channels 2 and 3 take theirs from MODE_HI.
- R9: If a capture happens while STAT bit 1+i is already set, STAT bit 9+i (overcapture) is set.
- R10: A write to STAT clears each flag whose bit is written 0 and leaves each flag whose bit is written 1. A flag that is set in the same cycle as the clear stays set.
- R11: Reading CAPTi clears STAT bit 1+i.
- R12: Mode bits [3:2] = 0/1/2/3 make the channel capture on every 1st/2nd/4th/8th qualifying edge. The edge count restarts whenever the channel is disabled.
- R13: Mode bits [7:4] = F accept a level change only after the synchronised input has held the new level for F+1 consecutive cycles. Shorter pulses are ignored.
- R14: `irq` is the OR of (STAT bit 0 AND IEN bit 0) and (STAT bit 1+i AND IEN bit 1+i). Overcapture flags never drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address: 0 CTRL, 1 EVGEN, 2 PRESC, 3 RATIO, 4 TOP, 5 COUNT, 6 IEN, 7 STAT, 8 MODE_LO, 9 MODE_HI, 10 CAPEN, 11..14 CAPT0..3 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| cap_in | input | 4 | Capture pins, asynchronous |
| irq | output | 1 | Combined interrupt |

## Verification
Two events can land on the same clock edge: a capture on a channel, and a software write that clears that channel's flag. The bench provokes this by raising channel 0's pin and then timing a STAT write of all zeros to commit on the edge where the synchronised edge is captured. That edge comes three clock edges after the pin change. The design must end with the capture flag set and no overcapture, because the flag was clear before. An interrupt that then appears shows that the new event was not lost.

// File: rtl/icap_pkg.sv
package icap_pkg;

   localparam int unsigned NUM_CH = 4;

   typedef enum logic [3:0] {
      A_CTRL    = 4'd0,
      A_EVGEN   = 4'd1,
      A_PRESC   = 4'd2,
      A_RATIO   = 4'd3,
      A_TOP     = 4'd4,
      A_COUNT   = 4'd5,
      A_IEN     = 4'd6,
      A_STAT    = 4'd7,
      A_MODE_LO = 4'd8,
      A_MODE_HI = 4'd9,
      A_CAPEN   = 4'd10,
      A_CAPT0   = 4'd11,
      A_CAPT1   = 4'd12,
      A_CAPT2   = 4'd13,
      A_CAPT3   = 4'd14
   } reg_addr_e;

   // per-channel mode byte
   typedef struct packed {
      logic [3:0] filt;   // run length - 1 needed to accept a level
      logic [1:0] psc;    // log2 of edges per capture
      logic [1:0] sel;    // 01 = pin routed to channel
   } chmode_t;

   // per-channel enable nibble
   typedef struct packed {
      logic npol;
      logic rsvd;
      logic pol;
      logic en;
   } chen_t;

   localparam logic [1:0] SEL_DIRECT = 2'b01;

endpackage

// File: rtl/icap_timebase.sv
module icap_timebase #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             use_ext,
   input  logic             ext_in,
   input  logic [DIV_W-1:0] div,
   input  logic [CNT_W-1:0] top,
   input  logic             restart,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam int unsigned SYNC_N = 3;

   logic [SYNC_N-1:0] ext_sr;
   logic [DIV_W-1:0]  phase;
   logic              ext_rise, tick, step;

   assign ext_rise = ext_sr[SYNC_N-2] & ~ext_sr[SYNC_N-1];
   assign tick     = run & (use_ext ? ext_rise : 1'b1);
   assign step     = tick & (phase >= div);
   assign wrap     = step & (count == top) & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_sr <= '0;
      end else begin
         ext_sr <= {ext_sr[SYNC_N-2:0], ext_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         count <= '0;
      end else if (restart) begin
         phase <= '0;
         count <= '0;
      end else if (tick) begin
         if (step) begin
            phase <= '0;
            count <= (count == top) ? '0 : count + 1'b1;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

endmodule

// File: rtl/icap_channel.sv
module icap_channel
   import icap_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  chen_t            cfg,
   input  chmode_t          mode,
   input  logic [CNT_W-1:0] count,
   output logic             cap_evt,
   output logic [CNT_W-1:0] cap_val
);
   logic       s1, s2, level;
   logic [3:0] fcnt;
   logic [2:0] ecnt, elim;
   logic       change, accept, rise, fall, hit, last;

   assign change = s2 != level;
   assign accept = change & (fcnt >= mode.filt);
   assign rise   = accept & s2;
   assign fall   = accept & ~s2;

   always_comb begin
      hit = 1'b0;
      if (cfg.en && mode.sel == SEL_DIRECT) begin
         if (!cfg.pol)      hit = rise;
         else if (cfg.npol) hit = accept;
         else               hit = fall;
      end
   end

   assign elim    = 3'((4'd1 << mode.psc) - 4'd1);
   assign last    = ecnt == elim;
   assign cap_evt = hit & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1    <= 1'b0;
         s2    <= 1'b0;
         level <= 1'b0;
         fcnt  <= '0;
      end else begin
         s1 <= pin;
         s2 <= s1;
         if (accept) begin
            level <= s2;
            fcnt  <= '0;
         end else if (change) begin
            fcnt <= fcnt + 1'b1;
         end else begin
            fcnt <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt <= '0;
      end else if (!cfg.en) begin
         ecnt <= '0;
      end else if (hit) begin
         ecnt <= last ? '0 : ecnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_val <= '0;
      else if (cap_evt) cap_val <= count;
   end

endmodule

// File: rtl/icap_timer.sv
module icap_timer
   import icap_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        ext_clk_in,
   input  logic [3:0]  cap_in,
   output logic        irq
);
   localparam int unsigned DIV_W   = 16;
   localparam int unsigned EN_W    = NUM_CH + 1;
   localparam int unsigned OVR_LSB = 9;

   generate
      if (CNT_W != 16 && CNT_W != 32) begin : g_bad_width
         $error("icap_timer: CNT_W must be 16 or 32");
      end
   endgenerate

   logic                     run_q, ext_q;
   logic [DIV_W-1:0]         presc_q;
   logic [CNT_W-1:0]         top_q;
   logic [EN_W-1:0]          ien_q;
   logic                     upd_q;
   logic [NUM_CH-1:0]        cap_q, ovr_q;
   chmode_t [NUM_CH-1:0]     mode_q;
   logic [4*NUM_CH-1:0]      capen_q;

   logic                     wr_en, rd_en, restart, stat_wr, ratio_stop, wrap;
   logic [31:0]              ratio_m1, cnt_rd;
   logic [CNT_W-1:0]         count_w;
   logic [NUM_CH-1:0]        cap_evt, rd_clr;
   logic [CNT_W-1:0]         cap_val [NUM_CH];
   logic [31:0]              cap_rd  [NUM_CH];

   assign wr_en      = bus_sel & bus_wr;
   assign rd_en      = bus_sel & ~bus_wr;
   assign restart    = wr_en && bus_addr == A_EVGEN && bus_wdata[0];
   assign stat_wr    = wr_en && bus_addr == A_STAT;
   assign ratio_stop = wr_en && bus_addr == A_RATIO && bus_wdata == '0;
   assign ratio_m1   = bus_wdata - 32'd1;

   icap_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) tb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .use_ext (ext_q),
      .ext_in  (ext_clk_in),
      .div     (presc_q),
      .top     (top_q),
      .restart (restart),
      .count   (count_w),
      .wrap    (wrap)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         icap_channel #(.CNT_W(CNT_W)) ch_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (cap_in[i]),
            .cfg     (chen_t'(capen_q[4*i +: 4])),
            .mode    (mode_q[i]),
            .count   (count_w),
            .cap_evt (cap_evt[i]),
            .cap_val (cap_val[i])
         );
         assign rd_clr[i] = rd_en && bus_addr == 4'(A_CAPT0 + i);
         if (CNT_W == 32) begin : g_wide
            assign cap_rd[i] = 32'(cap_val[i]);
         end else begin : g_narrow
            assign cap_rd[i] = {{(32-CNT_W){1'b0}}, cap_val[i]};
         end
      end
      if (CNT_W == 32) begin : g_cnt_wide
         assign cnt_rd = 32'(count_w);
      end else begin : g_cnt_narrow
         assign cnt_rd = {{(32-CNT_W){1'b0}}, count_w};
      end
   endgenerate

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         ext_q   <= 1'b0;
         presc_q <= '0;
         top_q   <= '1;
         ien_q   <= '0;
         mode_q  <= '0;
         capen_q <= '0;
      end else if (wr_en) begin
         case (bus_addr)
            A_CTRL: begin
               run_q <= bus_wdata[0];
               ext_q <= bus_wdata[1];
            end
            A_PRESC: presc_q <= bus_wdata[DIV_W-1:0];
            A_RATIO: begin
               if (bus_wdata == '0)        run_q   <= 1'b0;
               else if (ratio_m1 > 32'hFFFF) presc_q <= '1;
               else                        presc_q <= ratio_m1[DIV_W-1:0];
            end
            A_TOP:     top_q   <= bus_wdata[CNT_W-1:0];
            A_IEN:     ien_q   <= bus_wdata[EN_W-1:0];
            A_MODE_LO: mode_q[1:0] <= bus_wdata[15:0];
            A_MODE_HI: mode_q[3:2] <= bus_wdata[15:0];
            A_CAPEN:   capen_q <= bus_wdata[4*NUM_CH-1:0];
            default: ;
         endcase
      end
   end

   // status flags: a new event wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_q <= 1'b0;
         cap_q <= '0;
         ovr_q <= '0;
      end else begin
         upd_q <= wrap | (upd_q & (~stat_wr | bus_wdata[0]));
         for (int i = 0; i < NUM_CH; i++) begin
            cap_q[i] <= cap_evt[i] |
                        (cap_q[i] & (~stat_wr | bus_wdata[1+i]) & ~rd_clr[i]);
            ovr_q[i] <= (cap_evt[i] & cap_q[i]) |
                        (ovr_q[i] & (~stat_wr | bus_wdata[OVR_LSB+i]));
         end
      end
   end

   assign irq = |({cap_q, upd_q} & ien_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL:    bus_rdata = {30'd0, ext_q, run_q};
         A_PRESC:   bus_rdata = 32'(presc_q);
         A_TOP:     bus_rdata = 32'(top_q);
         A_COUNT:   bus_rdata = cnt_rd;
         A_IEN:     bus_rdata = 32'(ien_q);
         A_STAT:    bus_rdata = 32'({ovr_q, 4'd0, cap_q, upd_q});
         A_MODE_LO: bus_rdata = {16'd0, mode_q[1:0]};
         A_MODE_HI: bus_rdata = {16'd0, mode_q[3:2]};
         A_CAPEN:   bus_rdata = 32'(capen_q);
         A_CAPT0:   bus_rdata = cap_rd[0];
         A_CAPT1:   bus_rdata = cap_rd[1];
         A_CAPT2:   bus_rdata = cap_rd[2];
         A_CAPT3:   bus_rdata = cap_rd[3];
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/icap_timer_chk.sv
module icap_timer_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic [4:0]       ien_q,
   input logic             upd_q,
   input logic [3:0]       cap_q,
   input logic [3:0]       ovr_q,
   input logic [CNT_W-1:0] count_w,
   input logic             run_q,
   input logic             restart,
   input logic             ratio_stop,
   input logic [3:0]       rd_clr,
   input logic [3:0]       cap_evt
);

   // R14: no enable, no interrupt
   p_irq_needs_enable_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);

   // R3: the update flag rises only together with a wrap to zero
   p_update_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(upd_q) |-> (count_w == '0));

   // R2: a stopped counter holds unless restarted
   p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !restart) |=> $stable(count_w));

   // R5: ratio zero stops the timer
   p_ratio_zero_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_stop |=> !run_q);

   generate
      for (genvar i = 0; i < 4; i++) begin : g_prop
         // R11: reading the capture clears its flag unless a new capture lands
         p_read_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr[i] && !cap_evt[i]) |=> !cap_q[i]);
         // R9: overcapture rises only if the capture flag was already set
         p_over_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovr_q[i]) |-> $past(cap_q[i]));
      end
   endgenerate

endmodule

bind icap_timer icap_timer_chk #(.CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .ien_q      (ien_q),
   .upd_q      (upd_q),
   .cap_q      (cap_q),
   .ovr_q      (ovr_q),
   .count_w    (count_w),
   .run_q      (run_q),
   .restart    (restart),
   .ratio_stop (ratio_stop),
   .rd_clr     (rd_clr),
   .cap_evt    (cap_evt)
);

// File: tb/icap_timer_tb.sv
module icap_timer_tb_top;
   import icap_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ext_clk_in = 1'b0;
   logic [3:0]  cap_in = '0;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   icap_timer #(.CNT_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_clk_in(ext_clk_in), .cap_in(cap_in), .irq(irq)
   );

   // vector: [6:3] CAPEN nibble, [2] start level, [1] end level, [0] flag expected
   localparam logic [6:0] VEC [8] = '{
      {4'h1, 1'b0, 1'b1, 1'b1},
      {4'h1, 1'b1, 1'b0, 1'b0},
      {4'h3, 1'b0, 1'b1, 1'b0},
      {4'h3, 1'b1, 1'b0, 1'b1},
      {4'hB, 1'b0, 1'b1, 1'b1},
      {4'hB, 1'b1, 1'b0, 1'b1},
      {4'h0, 1'b0, 1'b1, 1'b0},
      {4'hA, 1'b0, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge; commits on the next posedge; returns at the following negedge
   task automatic wr(input reg_addr_e a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input reg_addr_e a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse0(input int n);
      for (int k = 0; k < n; k++) begin
         cap_in[0] = 1'b1; idle(4);
         cap_in[0] = 1'b0; idle(4);
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      logic [31:0] d;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_CTRL, d);  check("R1 ctrl", d, 0);
      rd(A_COUNT, d); check("R1 count", d, 0);
      rd(A_STAT, d);  check("R1 stat", d, 0);
      rd(A_TOP, d);   check("R1 top", d, 32'hFFFF);
      check("R1 irq", 32'(irq), 0);

      // R5 ratio conversion and saturation
      wr(A_RATIO, 32'h12345); rd(A_PRESC, d); check("R5 saturate", d, 32'hFFFF);
      wr(A_RATIO, 4);         rd(A_PRESC, d); check("R5 ratio-1", d, 3);

      // R4 + R2: 40 counting edges at divide-by-4 give 10
      wr(A_EVGEN, 1);
      wr(A_CTRL, 1);
      idle(39);
      wr(A_CTRL, 0);
      rd(A_COUNT, d); check("R2 count", d, 10);
      idle(10);
      rd(A_COUNT, d); check("R2 hold", d, 10);

      // R5 ratio zero stops, divider kept
      wr(A_CTRL, 1);
      wr(A_RATIO, 0);
      rd(A_CTRL, d);  check("R5 stop", d, 0);
      rd(A_PRESC, d); check("R5 keep", d, 3);
      rd(A_COUNT, d); check("R2 count after stop", d, 10);

      // R8 select field 00 blocks capture
      wr(A_CAPEN, 1);
      cap_in[0] = 1'b1; idle(6);
      rd(A_STAT, d); check("R8 unrouted", d, 0);
      cap_in[0] = 1'b0; idle(6);

      // R7 / R8 / R11 polarity table on channel 0
      wr(A_MODE_LO, 32'h01);
      for (int v = 0; v < 8; v++) begin
         cap_in[0] = VEC[v][2]; idle(6);
         wr(A_STAT, 0);
         wr(A_CAPEN, 32'(VEC[v][6:3]));
         cap_in[0] = VEC[v][1]; idle(6);
         rd(A_STAT, d); check($sformatf("R7 vec %0d", v), 32'(d[1]), 32'(VEC[v][0]));
         if (VEC[v][0]) begin
            rd(A_CAPT0, d); check("R8 value", d, 10);
            rd(A_STAT, d);  check("R11 read clears", 32'(d[1]), 0);
         end
      end
      wr(A_CAPEN, 0);
      cap_in[0] = 1'b0; idle(6);
      wr(A_STAT, 0);

      // R8 channel 1 takes its mode from the upper byte
      wr(A_MODE_LO, 32'h0100);
      wr(A_CAPEN, 32'h10);
      cap_in[1] = 1'b1; idle(6);
      rd(A_STAT, d); check("R8 upper byte", d, 32'h4);
      wr(A_CAPEN, 0); wr(A_STAT, 0);

      // R9 overcapture, R14 no irq from overcapture
      wr(A_MODE_LO, 32'h01);
      wr(A_CAPEN, 1);
      pulse0(2);
      rd(A_STAT, d); check("R9 over", d, 32'h202);
      wr(A_IEN, 32'h2);
      check("R14 cap irq", 32'(irq), 1);
      wr(A_STAT, ~32'h2);
      rd(A_STAT, d); check("R10 keep ones", d, 32'h200);
      check("R14 over no irq", 32'(irq), 0);
      wr(A_STAT, 0);

      // R10 capture and clear on the same edge
      cap_in[0] = 1'b1;
      idle(2);
      wr(A_STAT, 0);
      idle(3);
      rd(A_STAT, d); check("R10 set wins", d, 32'h2);
      check("R14 irq after race", 32'(irq), 1);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, d); check("R10 ones keep", d, 32'h2);
      wr(A_STAT, 0);
      rd(A_STAT, d); check("R10 zero clears", d, 0);
      wr(A_IEN, 0);
      cap_in[0] = 1'b0; idle(6);

      // R12 capture every 4th edge, count reset on disable
      wr(A_MODE_LO, 32'h09);
      wr(A_STAT, 0);
      pulse0(3);
      rd(A_STAT, d); check("R12 three edges", d, 0);
      pulse0(1);
      rd(A_STAT, d); check("R12 fourth edge", d, 32'h2);
      wr(A_STAT, 0);
      pulse0(2);
      wr(A_CAPEN, 0);
      wr(A_CAPEN, 1);
      pulse0(3);
      rd(A_STAT, d); check("R12 reset on disable", d, 0);
      pulse0(1);
      rd(A_STAT, d); check("R12 after re-enable", d, 32'h2);
      wr(A_STAT, 0);

      // R13 input filter of 5 samples
      wr(A_MODE_LO, 32'h41);
      cap_in[0] = 1'b1; idle(3);
      cap_in[0] = 1'b0; idle(10);
      rd(A_STAT, d); check("R13 glitch", d, 0);
      cap_in[0] = 1'b1; idle(8);
      rd(A_STAT, d); check("R13 long pulse", d, 32'h2);
      cap_in[0] = 1'b0; idle(10);
      wr(A_CAPEN, 0); wr(A_STAT, 0);

      // R3 wrap at top, R14 update interrupt
      wr(A_TOP, 5);
      wr(A_RATIO, 1);
      wr(A_EVGEN, 1);
      wr(A_CTRL, 1);
      idle(4);
      wr(A_CTRL, 0);
      rd(A_COUNT, d); check("R3 at top", d, 5);
      rd(A_STAT, d);  check("R3 no flag yet", d, 0);
      wr(A_CTRL, 1);
      wr(A_CTRL, 0);
      rd(A_COUNT, d); check("R3 wrapped", d, 0);
      rd(A_STAT, d);  check("R3 update flag", d, 1);
      check("R14 masked", 32'(irq), 0);
      wr(A_IEN, 1);
      check("R14 update irq", 32'(irq), 1);
      wr(A_STAT, 0);
      check("R14 irq cleared", 32'(irq), 0);

      // R6 external count source, R4 restart
      wr(A_EVGEN, 1);
      rd(A_COUNT, d); check("R4 restart", d, 0);
      wr(A_CTRL, 3);
      for (int k = 0; k < 3; k++) begin
         ext_clk_in = 1'b1; idle(4);
         ext_clk_in = 1'b0; idle(4);
      end
      idle(6);
      wr(A_CTRL, 0);
      rd(A_COUNT, d); check("R6 ext edges", d, 3);

      summary();
   end

endmodule